// File: doc/BRIEF.md
# Aliased Internal Register Address Decoder

This block sits between an internal byte-wide access port and the register targets behind it. The port is driven either by a host-bus bridge or by a start-up configuration loader. For every access it decides which target the 8-bit internal address reaches:

- the local configuration register bank;
- one of the per-UART register windows;
- a UART's two extended registers;
- the shared interrupt status register;
- one of the two enable registers that the decoder itself holds.

It produces one select strobe for the chosen target and returns that target's read data in the same cycle.

The address map is only partly decoded:

- In the range 40h–7Fh, address bit 5 is ignored.
- In the range C0h–FFh, address bits 5 and 4 are both ignored.

Each UART's windows are reachable only while its bit in the UART enable register is set. When the shared status register is enabled, it overrides the UART extended register that lies at the same location.

An address that reaches no target, for example a disabled UART's window, reads as zero. A write to such an address produces no strobe.

The decoded target is an enumerated value:

| Target | Meaning |
|---|---|
| TGT_NONE | no target, the address is treated as unmapped |
| TGT_CFG | local configuration bank |
| TGT_UEN | UART enable register |
| TGT_SEN | status enable register |
| TGT_UART | a UART window, basic or extended |
| TGT_STS | shared status register |

Each access resolves to one target in the same cycle; there are no multi-cycle states. The only transitions are register updates at a clock edge when TGT_UEN or TGT_SEN is written. These updates change how the following accesses resolve.

Top module: `uart_addr_decode`

## Requirements
- R1: An access to 00h–3Fh asserts cfg_sel with cfg_idx equal to address bits 6:0, and returns cfg_rdata.
- R2: In 40h–7Fh address bit 5 is ignored. The UART enable register is at 40h (alias 60h) and the status enable register at 42h (alias 62h); both are held inside the decoder and not forwarded. Every other address in the range asserts cfg_sel with cfg_idx bit 5 cleared.
- R3: An access to 80h–BFh selects UART n = address bits 5:3 (uart_sel bit n), with uart_reg = address bits 2:0, and returns byte n of uart_rdata.
- R4: In C0h–FFh address bits 5:4 are ignored. UART n register 8 sits at C0h+2n and register 9 at C0h+2n+1, so uart_reg = 8 + address bit 0.
- R5: While bit 7 of the status enable register is 1, an access whose bits 7:6 are 11b and bits 3:0 are 0h asserts sts_sel and returns sts_rdata, with no UART selected. While bit 7 is 0, the same address reaches UART 0 register 8.
- R6: Bit n of the UART enable register gates both windows of UART n. While that bit is 0, no uart_sel bit n is raised and reads there return 00h.
- R7: Accesses that reach no target read 00h. Writes to them raise no strobe and change no register.
- R8: After reset the UART enable register reads 00h and the status enable register reads 80h. The status enable register keeps only bit 7; its other bits read 0.
- R9: Read data is combinational in the access cycle. Selects are raised only while acc_rd or acc_wr is 1, and acc_rdata is 00h whenever acc_rd is 0.
- R10: A write to either enable register takes effect at the next clock edge and governs every later access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low asynchronous reset |
| acc_addr | input | 8 | internal byte address |
| acc_rd | input | 1 | read strobe |
| acc_wr | input | 1 | write strobe |
| acc_wdata | input | 8 | write data |
| acc_rdata | output | 8 | read data, valid in the access cycle |
| cfg_sel | output | 1 | configuration bank select |
| cfg_idx | output | 7 | normalised configuration bank offset |
| cfg_rdata | input | 8 | configuration bank read data |
| uart_sel | output | NUM_UART | one select per UART |
| uart_reg | output | 4 | UART register number 0–9 |
| uart_rdata | input | NUM_UART*8 | UART read data, byte n from UART n |
| sts_sel | output | 1 | shared status register select |
| sts_rdata | input | 8 | shared status read data |

## Verification
The assertions check on every cycle that at most one target strobe is raised. They also check that a disabled UART is never selected, and that the status register wins its shared location whenever it is enabled. Further per-cycle checks cover the configuration offset having bit 5 cleared in the aliased range, unmapped accesses reading zero, and enable-register writes landing on the next edge.

Only the bench's scenarios can show the complete address map. That covers the exact data returned through each alias, reset values read back at the ports, and writes to disabled windows leaving the enable registers untouched.

// File: rtl/uadec_pkg.sv
package uadec_pkg;

    localparam int ADDR_W = 8;
    localparam int DATA_W = 8;
    localparam int UNIT_W = 3;
    localparam int MAX_UNITS = 1 << UNIT_W;
    localparam logic [ADDR_W-1:0] UEN_ADDR = 8'h40;
    localparam logic [ADDR_W-1:0] SEN_ADDR = 8'h42;
    localparam int SEN_BIT = 7;

    typedef enum logic [2:0] {
        TGT_NONE,
        TGT_CFG,
        TGT_UEN,
        TGT_SEN,
        TGT_UART,
        TGT_STS
    } tgt_e;

    typedef struct packed {
        tgt_e              tgt;
        logic [UNIT_W-1:0] unit;
        logic [3:0]        reg_idx;
        logic [6:0]        cfg_idx;
    } dec_s;

endpackage

// File: rtl/uadec_alias.sv
module uadec_alias
    import uadec_pkg::*;
(
    input  logic [ADDR_W-1:0] raw_addr,
    output logic [ADDR_W-1:0] norm_addr
);

    always_comb begin
        unique case (raw_addr[7:6])
            2'b01:   norm_addr = {raw_addr[7:6], 1'b0, raw_addr[4:0]};
            2'b11:   norm_addr = {raw_addr[7:6], 2'b00, raw_addr[3:0]};
            default: norm_addr = raw_addr;
        endcase
    end

endmodule

// File: rtl/uadec_region.sv
module uadec_region
    import uadec_pkg::*;
#(
    parameter int NUM_UART = 8
) (
    input  logic [ADDR_W-1:0]   norm_addr,
    input  logic [NUM_UART-1:0] uen,
    input  logic                sts_en,
    output dec_s                dec
);

    logic [MAX_UNITS-1:0] uen_pad;
    logic [UNIT_W-1:0]    unit;
    logic                 unit_ok;

    always_comb begin
        uen_pad = '0;
        for (int i = 0; i < NUM_UART; i++) begin
            uen_pad[i] = uen[i];
        end
    end

    assign unit    = norm_addr[6] ? norm_addr[3:1] : norm_addr[5:3];
    assign unit_ok = (int'(unit) < NUM_UART) && uen_pad[unit];

    always_comb begin
        dec         = '0;
        dec.tgt     = TGT_NONE;
        dec.cfg_idx = norm_addr[6:0];
        unique case (norm_addr[7:6])
            2'b00: dec.tgt = TGT_CFG;
            2'b01: begin
                if (norm_addr == UEN_ADDR)      dec.tgt = TGT_UEN;
                else if (norm_addr == SEN_ADDR) dec.tgt = TGT_SEN;
                else                            dec.tgt = TGT_CFG;
            end
            2'b10: begin
                if (unit_ok) begin
                    dec.tgt     = TGT_UART;
                    dec.unit    = unit;
                    dec.reg_idx = {1'b0, norm_addr[2:0]};
                end
            end
            2'b11: begin
                if (sts_en && norm_addr[3:0] == 4'h0) begin
                    dec.tgt = TGT_STS;
                end else if (unit_ok) begin
                    dec.tgt     = TGT_UART;
                    dec.unit    = unit;
                    dec.reg_idx = {3'b100, norm_addr[0]};
                end
            end
            default: dec.tgt = TGT_NONE;
        endcase
    end

endmodule

// File: rtl/uadec_ctl.sv
module uadec_ctl
    import uadec_pkg::*;
#(
    parameter int NUM_UART = 8,
    parameter logic [NUM_UART-1:0] UEN_RST = '0
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_uen,
    input  logic                wr_sen,
    input  logic [DATA_W-1:0]   wdata,
    output logic [NUM_UART-1:0] uen,
    output logic                sts_en
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            uen    <= UEN_RST;
            sts_en <= 1'b1;
        end else begin
            if (wr_uen) uen    <= wdata[NUM_UART-1:0];
            if (wr_sen) sts_en <= wdata[SEN_BIT];
        end
    end

    a_r10_uen_update: assert property (@(posedge clk) disable iff (!rst_n)
        wr_uen |=> uen == $past(wdata[NUM_UART-1:0]));

    a_r10_sen_update: assert property (@(posedge clk) disable iff (!rst_n)
        wr_sen |=> sts_en == $past(wdata[SEN_BIT]));

    a_r7_regs_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_uen && !wr_sen) |=> ($stable(uen) && $stable(sts_en)));

endmodule

// File: rtl/uadec_rmux.sv
module uadec_rmux
    import uadec_pkg::*;
#(
    parameter int NUM_UART = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  dec_s                       dec,
    input  logic                       rd,
    input  logic [DATA_W-1:0]          cfg_rdata,
    input  logic [NUM_UART*DATA_W-1:0] uart_rdata,
    input  logic [DATA_W-1:0]          sts_rdata,
    input  logic [NUM_UART-1:0]        uen,
    input  logic                       sts_en,
    output logic [DATA_W-1:0]          rdata
);

    logic [MAX_UNITS-1:0][DATA_W-1:0] urd_pad;
    logic [DATA_W-1:0]                uen_byte;
    logic [DATA_W-1:0]                sel_data;

    always_comb begin
        urd_pad  = '0;
        uen_byte = '0;
        for (int i = 0; i < NUM_UART; i++) begin
            urd_pad[i]  = uart_rdata[i*DATA_W +: DATA_W];
            uen_byte[i] = uen[i];
        end
    end

    always_comb begin
        unique case (dec.tgt)
            TGT_CFG:  sel_data = cfg_rdata;
            TGT_UEN:  sel_data = uen_byte;
            TGT_SEN:  sel_data = {sts_en, 7'b0};
            TGT_UART: sel_data = urd_pad[dec.unit];
            TGT_STS:  sel_data = sts_rdata;
            default:  sel_data = '0;
        endcase
    end

    assign rdata = rd ? sel_data : '0;

    a_r7_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && dec.tgt == TGT_NONE) |-> rdata == '0);

    a_r8_sen_low_bits: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && dec.tgt == TGT_SEN) |-> rdata[6:0] == '0);

endmodule

// File: rtl/uart_addr_decode.sv
module uart_addr_decode
    import uadec_pkg::*;
#(
    parameter int NUM_UART = 8,
    parameter logic [NUM_UART-1:0] UEN_RST = '0
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [7:0]                 acc_addr,
    input  logic                       acc_rd,
    input  logic                       acc_wr,
    input  logic [7:0]                 acc_wdata,
    output logic [7:0]                 acc_rdata,
    output logic                       cfg_sel,
    output logic [6:0]                 cfg_idx,
    input  logic [7:0]                 cfg_rdata,
    output logic [NUM_UART-1:0]        uart_sel,
    output logic [3:0]                 uart_reg,
    input  logic [NUM_UART*8-1:0]      uart_rdata,
    output logic                       sts_sel,
    input  logic [7:0]                 sts_rdata
);

    logic [ADDR_W-1:0]   norm_addr;
    logic [NUM_UART-1:0] uen;
    logic                sts_en;
    logic                access;
    dec_s                dec;

    assign access = acc_rd | acc_wr;

    uadec_alias u_alias (
        .raw_addr  (acc_addr),
        .norm_addr (norm_addr)
    );

    uadec_region #(.NUM_UART(NUM_UART)) u_region (
        .norm_addr (norm_addr),
        .uen       (uen),
        .sts_en    (sts_en),
        .dec       (dec)
    );

    uadec_ctl #(.NUM_UART(NUM_UART), .UEN_RST(UEN_RST)) u_ctl (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_uen (acc_wr && dec.tgt == TGT_UEN),
        .wr_sen (acc_wr && dec.tgt == TGT_SEN),
        .wdata  (acc_wdata),
        .uen    (uen),
        .sts_en (sts_en)
    );

    uadec_rmux #(.NUM_UART(NUM_UART)) u_rmux (
        .clk        (clk),
        .rst_n      (rst_n),
        .dec        (dec),
        .rd         (acc_rd),
        .cfg_rdata  (cfg_rdata),
        .uart_rdata (uart_rdata),
        .sts_rdata  (sts_rdata),
        .uen        (uen),
        .sts_en     (sts_en),
        .rdata      (acc_rdata)
    );

    assign cfg_sel  = access && dec.tgt == TGT_CFG;
    assign cfg_idx  = (dec.tgt == TGT_CFG) ? dec.cfg_idx : '0;
    assign sts_sel  = access && dec.tgt == TGT_STS;
    assign uart_reg = (dec.tgt == TGT_UART) ? dec.reg_idx : '0;

    for (genvar g = 0; g < NUM_UART; g++) begin : g_usel
        assign uart_sel[g] = access && dec.tgt == TGT_UART && int'(dec.unit) == g;
    end

    a_r9_one_target: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cfg_sel, sts_sel, uart_sel}));

    a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !access |-> (!cfg_sel && !sts_sel && uart_sel == '0));

    a_r6_disabled_unselected: assert property (@(posedge clk) disable iff (!rst_n)
        (uart_sel & ~uen) == '0);

    a_r5_sts_priority: assert property (@(posedge clk) disable iff (!rst_n)
        (access && sts_en && acc_addr[7:6] == 2'b11 && acc_addr[3:0] == 4'h0)
        |-> (sts_sel && uart_sel == '0));

    a_r2_cfg_bit5_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_sel && acc_addr[7:6] == 2'b01) |-> !cfg_idx[5]);

    a_r3_upper_never_cfg: assert property (@(posedge clk) disable iff (!rst_n)
        acc_addr[7] |-> !cfg_sel);

endmodule

// File: tb/sim_uart_addr_decode.sv
module sim_uart_addr_decode;

    localparam int NU = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [7:0]    acc_addr = '0;
    logic          acc_rd = 1'b0;
    logic          acc_wr = 1'b0;
    logic [7:0]    acc_wdata = '0;
    logic [7:0]    acc_rdata;
    logic          cfg_sel;
    logic [6:0]    cfg_idx;
    logic [7:0]    cfg_rdata;
    logic [NU-1:0] uart_sel;
    logic [3:0]    uart_reg;
    logic [NU*8-1:0] uart_rdata;
    logic          sts_sel;
    logic [7:0]    sts_rdata = 8'hA5;

    int errors = 0;
    int checks = 0;

    always #10 clk = ~clk;

    assign cfg_rdata = {1'b1, cfg_idx};
    always_comb begin
        for (int n = 0; n < NU; n++) uart_rdata[n*8 +: 8] = {4'(n), uart_reg};
    end

    uart_addr_decode #(.NUM_UART(NU)) u0 (
        .clk(clk), .rst_n(rst_n), .acc_addr(acc_addr), .acc_rd(acc_rd),
        .acc_wr(acc_wr), .acc_wdata(acc_wdata), .acc_rdata(acc_rdata),
        .cfg_sel(cfg_sel), .cfg_idx(cfg_idx), .cfg_rdata(cfg_rdata),
        .uart_sel(uart_sel), .uart_reg(uart_reg), .uart_rdata(uart_rdata),
        .sts_sel(sts_sel), .sts_rdata(sts_rdata)
    );

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    // read: drive at negedge, sample combinational outputs 2 ns later
    task automatic rd_probe(input logic [7:0] a, output logic [7:0] d,
                            output logic [NU-1:0] us, output logic cs, output logic ss);
        @(negedge clk);
        acc_addr = a; acc_rd = 1'b1;
        #2;
        d = acc_rdata; us = uart_sel; cs = cfg_sel; ss = sts_sel;
        acc_rd = 1'b0;
    endtask

    task automatic wr_reg(input logic [7:0] a, input logic [7:0] v, output logic [NU-1:0] us);
        @(negedge clk);
        acc_addr = a; acc_wdata = v; acc_wr = 1'b1;
        #2;
        us = uart_sel;
        @(posedge clk);
        #1;
        acc_wr = 1'b0;
    endtask

    task automatic t_reset();
        logic [7:0] d; logic [NU-1:0] us; logic cs, ss;
        rd_probe(8'h40, d, us, cs, ss);
        check("R8 uen reset", d, 8'h00);
        rd_probe(8'h42, d, us, cs, ss);
        check("R8 sen reset", d, 8'h80);
        rd_probe(8'h9D, d, us, cs, ss);
        check("R6 disabled at reset data", d, 8'h00);
        check("R6 disabled at reset sel", us, '0);
    endtask

    task automatic t_cfg();
        logic [7:0] d; logic [NU-1:0] us; logic cs, ss;
        rd_probe(8'h15, d, us, cs, ss);
        check("R1 cfg sel", cs, 1'b1);
        check("R1 cfg data", d, 8'h95);
        rd_probe(8'h3F, d, us, cs, ss);
        check("R1 cfg top", d, 8'hBF);
        rd_probe(8'h6A, d, us, cs, ss);
        check("R2 alias bit5", d, 8'hCA);
    endtask

    task automatic t_enable_regs();
        logic [7:0] d; logic [NU-1:0] us; logic cs, ss;
        wr_reg(8'h60, 8'hFF, us);
        rd_probe(8'h40, d, us, cs, ss);
        check("R10 R2 uen via alias", d, 8'hFF);
        rd_probe(8'h62, d, us, cs, ss);
        check("R2 sen alias read", d, 8'h80);
        check("R2 sen not forwarded", cs, 1'b0);
    endtask

    task automatic t_uart();
        logic [7:0] d; logic [NU-1:0] us; logic cs, ss;
        rd_probe(8'h9D, d, us, cs, ss);
        check("R3 uart3 reg5 data", d, 8'h35);
        check("R3 uart3 sel", us, 8'h08);
        rd_probe(8'hBF, d, us, cs, ss);
        check("R3 uart7 reg7", d, 8'h77);
        rd_probe(8'hC5, d, us, cs, ss);
        check("R4 uart2 reg9", d, 8'h29);
        rd_probe(8'hF5, d, us, cs, ss);
        check("R4 alias F5", d, 8'h29);
    endtask

    task automatic t_status();
        logic [7:0] d; logic [NU-1:0] us; logic cs, ss;
        rd_probe(8'hC0, d, us, cs, ss);
        check("R5 sts data", d, 8'hA5);
        check("R5 sts sel", {ss, us}, {1'b1, 8'h00});
        rd_probe(8'hD0, d, us, cs, ss);
        check("R5 R4 sts alias D0", d, 8'hA5);
        wr_reg(8'h42, 8'h00, us);
        rd_probe(8'hC0, d, us, cs, ss);
        check("R5 sts off uart0 reg8", d, 8'h08);
        check("R5 sts off sel", {ss, us}, {1'b0, 8'h01});
        wr_reg(8'h42, 8'h7F, us);
        rd_probe(8'h42, d, us, cs, ss);
        check("R8 sen keeps bit7 only", d, 8'h00);
        wr_reg(8'h42, 8'h80, us);
        rd_probe(8'hE0, d, us, cs, ss);
        check("R10 sts restored", d, 8'hA5);
    endtask

    task automatic t_disable();
        logic [7:0] d; logic [NU-1:0] us; logic cs, ss;
        wr_reg(8'h40, 8'hF7, us);
        rd_probe(8'h9D, d, us, cs, ss);
        check("R6 uart3 off data", d, 8'h00);
        check("R6 uart3 off sel", us, '0);
        rd_probe(8'hC6, d, us, cs, ss);
        check("R6 uart3 ext off", d, 8'h00);
        wr_reg(8'h98, 8'h00, us);
        check("R7 write to disabled no strobe", us, '0);
        rd_probe(8'h40, d, us, cs, ss);
        check("R7 uen unchanged", d, 8'hF7);
        rd_probe(8'hA1, d, us, cs, ss);
        check("R6 uart4 still on", d, 8'h41);
    endtask

    task automatic t_idle();
        @(negedge clk);
        acc_addr = 8'hC5; acc_rd = 1'b0; acc_wr = 1'b0;
        #2;
        check("R9 idle rdata", acc_rdata, 8'h00);
        check("R9 idle sels", {cfg_sel, sts_sel, uart_sel}, '0);
    endtask

    initial begin
        #(20 * 5000);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_cfg();
        t_enable_regs();
        t_uart();
        t_status();
        t_disable();
        t_idle();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule